// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

This block stands between a set of interrupting sources and a processor core. Each source has a request line and a programmable priority. The block keeps the priority level of the task that is running. From the sources whose priority is strictly above that level, it picks exactly one winner. It then offers the winner to the core as a binary source code, together with two addresses:

- the address of the winner's slot in a vector table at a fixed base;
- the handler address stored in that slot, looked up in hardware.

The core does not have to poll any device to find out which one is asking.

The offer to the core is a valid/ready stream. `irq_valid` presents a registered offer, and `irq_ready` accepts it. While `irq_valid` is high and `irq_ready` is low, the core is applying back-pressure. During that time the offer holds still, even if the requests underneath it change.

Accepting an offer does two things. It raises the running level to the winner's priority, and it saves the old level on a four-deep stack. Because of this, only sources of strictly higher priority can nest on top of the accepted one. A return strobe restores the saved level. Software can also write the level directly. The core is expected to clear the source's request before it returns, so that the same request is not taken again.

Top module: `vec_irq_arbiter`

## Requirements
- R1: Among requests whose priority is strictly greater than the current level, the offered code is the one with the highest priority. Priorities are 3 bits, and source i's priority sits in `src_prio[3i+2:3i]`. Between equal priorities, the lowest source index wins.
- R2: A request whose priority is less than or equal to the current level is never offered. Because the level is never below 0, a priority of 0 is never offered.
- R3: While no offer is pending, a qualifying request produces `irq_valid` at the next clock edge. While `irq_valid` is high and `irq_ready` is low, `irq_code`, `irq_vec_addr` and `irq_handler` hold their values whatever the requests do.
- R4: `irq_vec_addr` equals VEC_BASE (default 0x100) plus 4 times `irq_code`.
- R5: `irq_handler` is the table entry at index `irq_code`, captured when the offer is made. The table has 8 entries of 32 bits. All entries reset to 0, and each is written through `cfg_wr_en`/`cfg_wr_idx`/`cfg_wr_data`.
- R6: When `irq_valid` and `irq_ready` are both high at a clock edge, that edge:
  - sets `cur_level` to the winner's priority;
  - pushes the previous level onto the stack;
  - drops `irq_valid`.

  Requests are re-evaluated against the new level from the next edge on.
- R7: `ret_strobe` restores the most recently pushed level. When the stack is empty, `ret_strobe` is ignored and the level stays where it is.
- R8: `lvl_wr_en` loads `lvl_wr_data` into the level. In the same cycle, an accept takes precedence over a return, and a return takes precedence over a write.
- R9: While four levels are nested, no new offer is made, whatever the priority, until a return frees a stack slot.
- R10: After reset, `irq_valid` is 0, and `cur_level`, `irq_code`, `irq_vec_addr` and `irq_handler` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 8 | Request line per source |
| src_prio | input | 24 | Packed 3-bit priority per source |
| lvl_wr_en | input | 1 | Direct write of the running level |
| lvl_wr_data | input | 3 | Level value to write |
| irq_ready | input | 1 | Core accepts the offer |
| ret_strobe | input | 1 | Return from handler: restore saved level |
| cfg_wr_en | input | 1 | Vector table write enable |
| cfg_wr_idx | input | 3 | Vector table entry to write |
| cfg_wr_data | input | 32 | Handler address to store |
| irq_valid | output | 1 | Offer to the core is valid |
| irq_code | output | 3 | Binary code of the winning source |
| irq_vec_addr | output | 32 | Address of the winner's vector slot |
| irq_handler | output | 32 | Handler address read from the table |
| cur_level | output | 3 | Current running priority level |

## Verification
A wrong saved level shows up on `cur_level` one edge after the return that pops it. It also shows up one edge later still, as an offer that appears or fails to appear. A wrong nesting count shows up the same way: as a missing offer at depth three, or an extra offer at depth four, two edges after an accept or return. A corrupted table entry or a wrong selection is visible on the very edge that makes the offer.

// File: rtl/via_pkg.sv
package via_pkg;
  // Action applied to the running level in a cycle, resolved in priority order.
  typedef enum logic [1:0] {
    LVL_HOLD  = 2'd0,
    LVL_PUSH  = 2'd1,
    LVL_POP   = 2'd2,
    LVL_WRITE = 2'd3
  } lvl_act_e;
endpackage

// File: rtl/via_select.sv
module via_select #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int CODE_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        req,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]         cur_lvl,
  output logic                      found,
  output logic [CODE_W-1:0]         win_idx,
  output logic [PRIO_W-1:0]         win_prio
);
  logic [PRIO_W-1:0] prio_arr [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign prio_arr[g] = prio_flat[g*PRIO_W +: PRIO_W];
  end

  // Linear scan: strict "greater" keeps the lowest index among equals.
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (prio_arr[i] > cur_lvl) && (!found || (prio_arr[i] > win_prio))) begin
        found    = 1'b1;
        win_idx  = CODE_W'(i);
        win_prio = prio_arr[i];
      end
    end
  end
endmodule

// File: rtl/via_vec_table.sv
module via_vec_table #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                                  mem[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))     mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/via_level_stack.sv
module via_level_stack
  import via_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lvl_act_e          act,
  input  logic [PRIO_W-1:0] new_lvl,
  output logic [PRIO_W-1:0] cur_lvl,
  output logic              full,
  output logic              empty
);
  logic [PRIO_W-1:0] saved [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;

  assign full   = (cnt == CNT_W'(DEPTH));
  assign empty  = (cnt == '0);
  assign wr_ptr = cnt[PTR_W-1:0];
  assign rd_ptr = wr_ptr - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_lvl <= '0;
      cnt     <= '0;
      for (int i = 0; i < DEPTH; i++) saved[i] <= '0;
    end else begin
      unique case (act)
        LVL_PUSH: if (!full) begin
          saved[wr_ptr] <= cur_lvl;
          cnt           <= cnt + 1'b1;
          cur_lvl       <= new_lvl;
        end
        LVL_POP: if (!empty) begin
          cur_lvl <= saved[rd_ptr];
          cnt     <= cnt - 1'b1;
        end
        LVL_WRITE: cur_lvl <= new_lvl;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
  import via_pkg::*;
#(
  parameter int           NUM_SRC   = 8,
  parameter int           PRIO_W    = 3,
  parameter int           ADDR_W    = 32,
  parameter int           NEST_MAX  = 4,
  parameter logic [31:0]  VEC_BASE  = 32'h0000_0100,
  localparam int          CODE_W    = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_req,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic                      lvl_wr_en,
  input  logic [PRIO_W-1:0]         lvl_wr_data,
  input  logic                      irq_ready,
  input  logic                      ret_strobe,
  input  logic                      cfg_wr_en,
  input  logic [CODE_W-1:0]         cfg_wr_idx,
  input  logic [ADDR_W-1:0]         cfg_wr_data,
  output logic                      irq_valid,
  output logic [CODE_W-1:0]         irq_code,
  output logic [ADDR_W-1:0]         irq_vec_addr,
  output logic [ADDR_W-1:0]         irq_handler,
  output logic [PRIO_W-1:0]         cur_level
);
  logic              cand_found;
  logic [CODE_W-1:0] cand_idx;
  logic [PRIO_W-1:0] cand_prio;
  logic [ADDR_W-1:0] tbl_rd;
  logic [PRIO_W-1:0] held_prio;
  logic              stk_full;
  logic              stk_empty;
  logic              accept;
  logic              load;
  lvl_act_e          lvl_act;
  logic [PRIO_W-1:0] lvl_new;

  via_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_select (
    .req      (src_req),
    .prio_flat(src_prio),
    .cur_lvl  (cur_level),
    .found    (cand_found),
    .win_idx  (cand_idx),
    .win_prio (cand_prio)
  );

  via_vec_table #(.DEPTH(NUM_SRC), .DATA_W(ADDR_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_en),
    .wr_idx (cfg_wr_idx),
    .wr_data(cfg_wr_data),
    .rd_idx (cand_idx),
    .rd_data(tbl_rd)
  );

  assign accept = irq_valid && irq_ready;
  assign load   = !irq_valid && cand_found && !stk_full;

  // Accept beats return, return beats direct write.
  always_comb begin
    if (accept)          lvl_act = LVL_PUSH;
    else if (ret_strobe) lvl_act = LVL_POP;
    else if (lvl_wr_en)  lvl_act = LVL_WRITE;
    else                 lvl_act = LVL_HOLD;
    lvl_new = accept ? held_prio : lvl_wr_data;
  end

  via_level_stack #(.PRIO_W(PRIO_W), .DEPTH(NEST_MAX)) u_level (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (lvl_act),
    .new_lvl(lvl_new),
    .cur_lvl(cur_level),
    .full   (stk_full),
    .empty  (stk_empty)
  );

  // Registered offer; frozen while the core back-pressures.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid    <= 1'b0;
      irq_code     <= '0;
      irq_vec_addr <= '0;
      irq_handler  <= '0;
      held_prio    <= '0;
    end else if (accept) begin
      irq_valid <= 1'b0;
    end else if (load) begin
      irq_valid    <= 1'b1;
      irq_code     <= cand_idx;
      irq_vec_addr <= ADDR_W'(VEC_BASE) + (ADDR_W'(cand_idx) << 2);
      irq_handler  <= tbl_rd;
      held_prio    <= cand_prio;
    end
  end
endmodule

// File: rtl/vec_irq_arbiter_chk.sv
module vec_irq_arbiter_chk #(
  parameter int          NUM_SRC  = 8,
  parameter int          PRIO_W   = 3,
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] VEC_BASE = 32'h0000_0100,
  localparam int         CODE_W   = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_req,
  input logic               irq_valid,
  input logic               irq_ready,
  input logic               ret_strobe,
  input logic               stk_empty,
  input logic               stk_full,
  input logic [CODE_W-1:0]  irq_code,
  input logic [ADDR_W-1:0]  irq_vec_addr,
  input logic [ADDR_W-1:0]  irq_handler,
  input logic [PRIO_W-1:0]  cur_level
);
  assert_hold_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_code) && $stable(irq_vec_addr) && $stable(irq_handler)));

  assert_offer_from_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> ((($past(src_req) >> irq_code) & NUM_SRC'(1)) != '0));

  assert_vec_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vec_addr == ADDR_W'(VEC_BASE) + (ADDR_W'(irq_code) << 2)));

  assert_accept_drops_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> !irq_valid);

  assert_accept_raises_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> (cur_level > $past(cur_level)));

  assert_empty_return_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && stk_empty && !(irq_valid && irq_ready)) |=> $stable(cur_level));

  assert_no_offer_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_full && !irq_valid) |=> !irq_valid);
endmodule

bind vec_irq_arbiter vec_irq_arbiter_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .irq_valid(irq_valid),
  .irq_ready(irq_ready), .ret_strobe(ret_strobe), .stk_empty(stk_empty),
  .stk_full(stk_full), .irq_code(irq_code), .irq_vec_addr(irq_vec_addr),
  .irq_handler(irq_handler), .cur_level(cur_level)
);

// File: tb/test_vec_irq_arbiter.sv
module test_vec_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_req = '0;
  logic [23:0] src_prio = '0;
  logic        lvl_wr_en = 1'b0;
  logic [2:0]  lvl_wr_data = '0;
  logic        irq_ready = 1'b0;
  logic        ret_strobe = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_wr_idx = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        irq_valid;
  logic [2:0]  irq_code;
  logic [31:0] irq_vec_addr;
  logic [31:0] irq_handler;
  logic [2:0]  cur_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vec_irq_arbiter i_vec_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_prio(src_prio),
    .lvl_wr_en(lvl_wr_en), .lvl_wr_data(lvl_wr_data), .irq_ready(irq_ready),
    .ret_strobe(ret_strobe), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_data(cfg_wr_data), .irq_valid(irq_valid), .irq_code(irq_code),
    .irq_vec_addr(irq_vec_addr), .irq_handler(irq_handler), .cur_level(cur_level)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [23:0] prio;
    logic        ev;
    logic [2:0]  code;
    logic [2:0]  lvl;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 24'h000005, 1'b1, 3'd0, 3'd5},
    '{8'h06, 24'h000190, 1'b1, 3'd2, 3'd6},
    '{8'hA0, 24'h820000, 1'b1, 3'd5, 3'd4},
    '{8'h08, 24'h000000, 1'b0, 3'd0, 3'd0},
    '{8'hFF, 24'hFFFFFF, 1'b1, 3'd0, 3'd7},
    '{8'h80, 24'h200000, 1'b1, 3'd7, 3'd1},
    '{8'h12, 24'h003018, 1'b1, 3'd1, 3'd3}
  };

  function automatic logic [31:0] hnd(input int i);
    return 32'h8000_0000 | (32'(i) << 8);
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src_req = '0; src_prio = '0; irq_ready = 1'b0;
    ret_strobe = 1'b0; lvl_wr_en = 1'b0; cfg_wr_en = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic fill_table();
    for (int i = 0; i < 8; i++) begin
      cfg_wr_en = 1'b1; cfg_wr_idx = 3'(i); cfg_wr_data = hnd(i);
      tick();
    end
    cfg_wr_en = 1'b0;
  endtask

  task automatic accept();
    irq_ready = 1'b1; tick(); irq_ready = 1'b0;
  endtask

  task automatic ret();
    ret_strobe = 1'b1; tick(); ret_strobe = 1'b0;
  endtask

  // Single source s with priority p, all others idle.
  task automatic one_req(input int s, input int p);
    src_req = 8'(1 << s);
    src_prio = 24'(p) << (3 * s);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R10 reset state
    chk("R10 valid", 32'(irq_valid), 32'd0);
    chk("R10 level", 32'(cur_level), 32'd0);
    chk("R10 code", 32'(irq_code), 32'd0);
    chk("R10 vec", irq_vec_addr, 32'd0);
    chk("R10 handler", irq_handler, 32'd0);

    // R5: empty table gives handler 0
    one_req(3, 2); tick();
    chk("R5 reset entry", irq_handler, 32'd0);
    src_req = '0; accept(); ret();
    fill_table();

    // Vector walk: R1 R2 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      src_req = VECS[v].req; src_prio = VECS[v].prio;
      tick();
      chk("R1 R2 valid", 32'(irq_valid), 32'(VECS[v].ev));
      if (VECS[v].ev) begin
        chk("R1 code", 32'(irq_code), 32'(VECS[v].code));
        chk("R4 vec", irq_vec_addr, 32'h100 + 32'(VECS[v].code) * 4);
        chk("R5 handler", irq_handler, hnd(int'(VECS[v].code)));
        src_req = '0;
        accept();
        chk("R6 level", 32'(cur_level), 32'(VECS[v].lvl));
        chk("R6 valid drop", 32'(irq_valid), 32'd0);
        ret();
        chk("R7 pop", 32'(cur_level), 32'd0);
      end else begin
        src_req = '0; tick();
      end
    end

    // R3 hold under back-pressure, then nesting
    do_reset(); fill_table();
    one_req(2, 3); tick();
    chk("R3 offer", 32'(irq_valid), 32'd1);
    one_req(6, 7); tick(); tick();
    chk("R3 held code", 32'(irq_code), 32'd2);
    chk("R3 held handler", irq_handler, hnd(2));
    accept();
    chk("R6 level 3", 32'(cur_level), 32'd3);
    chk("R6 valid low", 32'(irq_valid), 32'd0);
    tick();
    chk("R6 nested offer", 32'(irq_code), 32'd6);
    src_req = '0; accept();
    chk("R6 level 7", 32'(cur_level), 32'd7);
    one_req(1, 7); tick(); tick();
    chk("R2 equal level blocked", 32'(irq_valid), 32'd0);
    src_req = '0;
    ret(); chk("R7 pop to 3", 32'(cur_level), 32'd3);
    ret(); chk("R7 pop to 0", 32'(cur_level), 32'd0);
    ret(); chk("R7 empty ignored", 32'(cur_level), 32'd0);

    // R8 direct write and precedence
    lvl_wr_en = 1'b1; lvl_wr_data = 3'd5; tick(); lvl_wr_en = 1'b0;
    chk("R8 write", 32'(cur_level), 32'd5);
    one_req(4, 5); tick(); tick();
    chk("R8 at level blocked", 32'(irq_valid), 32'd0);
    one_req(4, 6); tick();
    chk("R8 above level", 32'(irq_valid), 32'd1);
    src_req = '0;
    lvl_wr_en = 1'b1; lvl_wr_data = 3'd1; ret_strobe = 1'b1; irq_ready = 1'b1;
    tick();
    lvl_wr_en = 1'b0; ret_strobe = 1'b0; irq_ready = 1'b0;
    chk("R8 accept wins", 32'(cur_level), 32'd6);
    lvl_wr_en = 1'b1; lvl_wr_data = 3'd2; ret_strobe = 1'b1; tick();
    lvl_wr_en = 1'b0; ret_strobe = 1'b0;
    chk("R8 return wins", 32'(cur_level), 32'd5);

    // R9 nesting limit
    do_reset();
    for (int k = 0; k < 4; k++) begin
      one_req(k, k + 1); tick();
      src_req = '0; accept();
    end
    chk("R9 depth level", 32'(cur_level), 32'd4);
    one_req(4, 7); tick(); tick();
    chk("R9 full blocks", 32'(irq_valid), 32'd0);
    ret();
    chk("R9 after return level", 32'(cur_level), 32'd3);
    tick();
    chk("R9 offer resumes", 32'(irq_valid), 32'd1);
    chk("R9 offer code", 32'(irq_code), 32'd4);

    // R5 table rewrite seen by next offer
    do_reset();
    cfg_wr_en = 1'b1; cfg_wr_idx = 3'd5; cfg_wr_data = 32'h1234_5678; tick();
    cfg_wr_en = 1'b0;
    one_req(5, 1); tick();
    chk("R5 rewritten entry", irq_handler, 32'h1234_5678);

    summary();
  end
endmodule